// File: doc/BRIEF.md
# Segmented Instruction Cache for a 16-bit Coprocessor

This block is the on-chip program store of a small 16-bit coprocessor. It keeps 512 bytes of code, grouped into 32 lines of 16 bytes, and each line carries its own valid bit. The cache mirrors a region of external memory. The start of that region is held in a 16-bit cache-base register whose value is always a multiple of 16. Loading a new base invalidates every line at once. That load is the flush, and it is issued both by the cache-set command and by a long jump.

Three sources reach the storage. A host port sees all 512 bytes as one flat window in the coprocessor's register page, and can read or write each byte there. The coprocessor's fetch port presents a 9-bit offset. If the line is valid, the fetch port returns an opcode byte. If the line is invalid, it reports a miss, and the block then fetches the whole line from an external memory model through a fill port, lowest byte first. A line becomes valid only when its last byte (byte 15) has been written, from either source. A line that is only partly loaded is therefore never executed.

Top module: `seg_icache`

## Requirements
- R1: Host offsets 0x100 to 0x2FF map onto cache bytes 0 to 511, and `host_rdata` is valid one cycle after `host_re`. A read outside the window returns 0x00. A write outside the window changes no cache byte.
- R2: A fetch to an offset whose line is invalid sets `fetch_miss` for one cycle, one cycle after the request, with `fetch_ready` low. From that same cycle, `fill_req` is high.
- R3: A line becomes valid only when its byte 15 is written, meaning an offset with bits [3:0] equal to 15. A fetch to a valid line gives `fetch_ready` together with the byte one cycle after the request. A line with any number of earlier bytes written, but without byte 15, still misses.
- R4: `base_load` sets the cache base to `base_val` with bits [3:0] forced to 0, and clears all 32 valid bits on the same clock edge. If `base_load` arrives in the same cycle as a line completion, the clear wins.
- R5: While `fill_req` is high, `fill_addr` equals the cache base + line×16 + i, for i from 0 to 15 in ascending order. The index i advances by one for each cycle in which `fill_valid` is high, and holds while `fill_valid` is low.
- R6: After the 16th fill byte, the line is valid and `fill_req` is low in the next cycle. `fetch_ready` follows one cycle later, carrying the byte at the missed offset.
- R7: While a fill is in progress, `fetch_req` is ignored. It does not change the fill addresses, and it raises neither `fetch_miss` nor `fetch_ready`.
- R8: A host write to a byte of the line being filled takes priority over the fill byte for that position. This holds whether the host write comes earlier than the fill byte or in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host byte write strobe |
| host_re | input | 1 | Host byte read strobe |
| host_addr | input | 10 | Host offset in the register page |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, one cycle after `host_re` |
| base_load | input | 1 | Load a new cache base and flush all lines |
| base_val | input | 16 | New cache base value |
| cbase | output | 16 | Current cache base, bits [3:0] always zero |
| fetch_req | input | 1 | Opcode fetch request |
| fetch_off | input | 9 | Offset of the opcode inside the cache |
| fetch_ready | output | 1 | Opcode byte valid on `fetch_data` |
| fetch_miss | output | 1 | One-cycle miss indication |
| fetch_data | output | 8 | Opcode byte |
| fill_req | output | 1 | Line fill in progress; a byte is wanted |
| fill_addr | output | 16 | External address of the requested byte |
| fill_valid | input | 1 | Fill byte present this cycle |
| fill_data | input | 8 | Fill byte |

## Verification
The fetch function is driven with several patterns, and each separates a different fault:
- An untouched line after reset exposes a stuck or preset valid bit.
- A line with bytes 0 to 14 written by the host must still miss, which catches completion on the wrong byte.
- A full host-written line and a two-byte "short program" (byte 0 plus byte 15) must both hit, which shows that byte 15 alone completes a line.
- A fetch after a fresh base load must miss, which catches a missing flush.

Each fill is compared byte by byte against a bench memory model, checking that the address sequence climbs from the aligned base. A stray fetch is issued in the middle of one fill to show that it is ignored. Host writes made before and alongside a fill byte to the same line separate host-wins from fill-wins.

// File: rtl/icache_pkg.sv
package icache_pkg;
  typedef enum logic [1:0] {
    FILL_IDLE   = 2'd0,
    FILL_BUSY   = 2'd1,
    FILL_REPLAY = 2'd2
  } fill_st_e;
endpackage

// File: rtl/icache_store.sv
module icache_store #(
  parameter int DEPTH = 512,
  parameter int AW    = 9
) (
  input  logic          clk,
  input  logic          a_we,
  input  logic          a_re,
  input  logic [AW-1:0] a_addr,
  input  logic [7:0]    a_wdata,
  output logic [7:0]    a_rdata,
  input  logic          b_we,
  input  logic          b_re,
  input  logic [AW-1:0] b_addr,
  input  logic [7:0]    b_wdata,
  output logic [7:0]    b_rdata
);
  logic [7:0] mem [DEPTH];

  // port A (host) is written last so it takes the byte on an address clash
  always_ff @(posedge clk) begin
    if (b_we) mem[b_addr] <= b_wdata;
    if (a_we) mem[a_addr] <= a_wdata;
  end

  always_ff @(posedge clk) begin
    if (a_re) a_rdata <= mem[a_addr];
    if (b_re) b_rdata <= mem[b_addr];
  end

  // R8
  host_beats_fill_chk: assert property (@(posedge clk)
    (a_we && b_we && a_addr == b_addr) |=> mem[$past(a_addr)] == $past(a_wdata));
endmodule

// File: rtl/icache_tags.sv
module icache_tags #(
  parameter int NUM_LINES = 32,
  parameter int LINE_W    = 5,
  parameter int IDX_W     = 4,
  parameter int BASE_W    = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 base_load,
  input  logic [BASE_W-1:0]    base_val,
  input  logic                 host_set,
  input  logic [LINE_W-1:0]    host_line,
  input  logic                 fill_set,
  input  logic [LINE_W-1:0]    fill_line,
  output logic [NUM_LINES-1:0] valid_q,
  output logic [BASE_W-1:0]    cbase_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      cbase_q <= '0;
    end else if (base_load) begin
      valid_q <= '0;
      cbase_q <= {base_val[BASE_W-1:IDX_W], {IDX_W{1'b0}}};
    end else begin
      if (host_set) valid_q[host_line] <= 1'b1;
      if (fill_set) valid_q[fill_line] <= 1'b1;
    end
  end

  // R4
  flush_all_chk: assert property (@(posedge clk) disable iff (rst)
    base_load |=> valid_q == '0);
  // R4
  base_align_chk: assert property (@(posedge clk) disable iff (rst)
    base_load |=> (cbase_q[BASE_W-1:IDX_W] == $past(base_val[BASE_W-1:IDX_W]) &&
                   cbase_q[IDX_W-1:0] == '0));
  // R3
  no_early_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(host_set) && !$past(fill_set)) |-> (valid_q & ~$past(valid_q)) == '0);
endmodule

// File: rtl/icache_fill_ctl.sv
module icache_fill_ctl
  import icache_pkg::*;
#(
  parameter int LINE_W = 5,
  parameter int IDX_W  = 4,
  parameter int OFF_W  = LINE_W + IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fetch_req,
  input  logic [OFF_W-1:0]  fetch_off,
  input  logic              line_valid,
  input  logic              fill_valid,
  input  logic              host_wr,
  input  logic [OFF_W-1:0]  host_off,
  output logic              fetch_ready,
  output logic              fetch_miss,
  output logic              fill_req,
  output logic [LINE_W-1:0] fill_line,
  output logic [IDX_W-1:0]  fill_idx,
  output logic              fill_we,
  output logic              fill_set,
  output logic              port_re,
  output logic [OFF_W-1:0]  port_addr
);
  localparam int LINE_BYTES = 1 << IDX_W;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(LINE_BYTES - 1);

  fill_st_e                state_q;
  logic [LINE_W-1:0]       line_q;
  logic [IDX_W-1:0]        idx_q;
  logic [OFF_W-1:0]        pend_q;
  logic [LINE_BYTES-1:0]   mask_q;
  logic                    idle, busy, replay, hit, miss;

  assign idle   = (state_q == FILL_IDLE);
  assign busy   = (state_q == FILL_BUSY);
  assign replay = (state_q == FILL_REPLAY);
  assign hit    = idle && fetch_req && line_valid;
  assign miss   = idle && fetch_req && !line_valid;

  assign fill_req  = busy;
  assign fill_line = line_q;
  assign fill_idx  = idx_q;
  assign fill_we   = busy && fill_valid && !mask_q[idx_q];
  assign fill_set  = busy && fill_valid && (idx_q == LAST);
  assign port_re   = hit || replay;
  assign port_addr = busy ? {line_q, idx_q} : (replay ? pend_q : fetch_off);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= FILL_IDLE;
      line_q      <= '0;
      idx_q       <= '0;
      pend_q      <= '0;
      mask_q      <= '0;
      fetch_ready <= 1'b0;
      fetch_miss  <= 1'b0;
    end else begin
      fetch_ready <= hit || replay;
      fetch_miss  <= miss;
      case (state_q)
        FILL_IDLE: if (miss) begin
          state_q <= FILL_BUSY;
          line_q  <= fetch_off[OFF_W-1:IDX_W];
          idx_q   <= '0;
          pend_q  <= fetch_off;
          mask_q  <= '0;
        end
        FILL_BUSY: begin
          if (host_wr && host_off[OFF_W-1:IDX_W] == line_q)
            mask_q[host_off[IDX_W-1:0]] <= 1'b1;
          if (fill_valid) begin
            idx_q <= idx_q + 1'b1;
            if (idx_q == LAST) state_q <= FILL_REPLAY;
          end
        end
        default: state_q <= FILL_IDLE;
      endcase
    end
  end

  // R2
  miss_starts_fill_chk: assert property (@(posedge clk) disable iff (rst)
    fetch_miss |-> (fill_req && !fetch_ready));
  // R5
  fill_index_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (fill_req && !fill_valid) |=> (fill_req && $stable(fill_idx) && $stable(fill_line)));
  // R6
  ready_after_fill_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(fill_req) |=> fetch_ready);
  // R7
  quiet_during_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (fill_req && $past(fill_req)) |-> (!fetch_ready && !fetch_miss));
endmodule

// File: rtl/seg_icache.sv
module seg_icache #(
  parameter int                  LINE_BYTES = 16,
  parameter int                  NUM_LINES  = 32,
  parameter int                  HOST_AW    = 10,
  parameter int                  BASE_W     = 16,
  parameter logic [HOST_AW-1:0]  WIN_BASE   = 10'h100
) (
  input  logic                                             clk,
  input  logic                                             rst,
  input  logic                                             host_we,
  input  logic                                             host_re,
  input  logic [HOST_AW-1:0]                               host_addr,
  input  logic [7:0]                                       host_wdata,
  output logic [7:0]                                       host_rdata,
  input  logic                                             base_load,
  input  logic [BASE_W-1:0]                                base_val,
  output logic [BASE_W-1:0]                                cbase,
  input  logic                                             fetch_req,
  input  logic [$clog2(LINE_BYTES*NUM_LINES)-1:0]          fetch_off,
  output logic                                             fetch_ready,
  output logic                                             fetch_miss,
  output logic [7:0]                                       fetch_data,
  output logic                                             fill_req,
  output logic [BASE_W-1:0]                                fill_addr,
  input  logic                                             fill_valid,
  input  logic [7:0]                                       fill_data
);
  localparam int DEPTH  = LINE_BYTES * NUM_LINES;
  localparam int OFF_W  = $clog2(DEPTH);
  localparam int IDX_W  = $clog2(LINE_BYTES);
  localparam int LINE_W = OFF_W - IDX_W;

  logic [HOST_AW-1:0]   host_rel;
  logic                 in_win, host_wr, host_rd, win_rd_q;
  logic [OFF_W-1:0]     host_off;
  logic                 host_set;
  logic [NUM_LINES-1:0] valid_q;
  logic                 line_valid;
  logic [7:0]           a_rdata, b_rdata;
  logic [LINE_W-1:0]    fill_line;
  logic [IDX_W-1:0]     fill_idx;
  logic                 fill_we, fill_set, port_re;
  logic [OFF_W-1:0]     port_addr;

  // host window decode
  assign host_rel = host_addr - WIN_BASE;
  assign in_win   = (host_addr >= WIN_BASE) && (host_rel < HOST_AW'(DEPTH));
  assign host_off = host_rel[OFF_W-1:0];
  assign host_wr  = host_we && in_win;
  assign host_rd  = host_re && in_win;
  assign host_set = host_wr && (host_off[IDX_W-1:0] == {IDX_W{1'b1}});

  always_ff @(posedge clk) begin
    if (rst) win_rd_q <= 1'b0;
    else     win_rd_q <= host_rd;
  end
  assign host_rdata = win_rd_q ? a_rdata : 8'h00;

  assign line_valid = valid_q[fetch_off[OFF_W-1:IDX_W]];
  assign fetch_data = b_rdata;
  assign fill_addr  = cbase + BASE_W'({fill_line, fill_idx});

  icache_store #(.DEPTH(DEPTH), .AW(OFF_W)) u_store (
    .clk(clk),
    .a_we(host_wr), .a_re(host_rd), .a_addr(host_off), .a_wdata(host_wdata), .a_rdata(a_rdata),
    .b_we(fill_we), .b_re(port_re), .b_addr(port_addr), .b_wdata(fill_data), .b_rdata(b_rdata)
  );

  icache_tags #(.NUM_LINES(NUM_LINES), .LINE_W(LINE_W), .IDX_W(IDX_W), .BASE_W(BASE_W)) u_tags (
    .clk(clk), .rst(rst),
    .base_load(base_load), .base_val(base_val),
    .host_set(host_set), .host_line(host_off[OFF_W-1:IDX_W]),
    .fill_set(fill_set), .fill_line(fill_line),
    .valid_q(valid_q), .cbase_q(cbase)
  );

  icache_fill_ctl #(.LINE_W(LINE_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_ctl (
    .clk(clk), .rst(rst),
    .fetch_req(fetch_req), .fetch_off(fetch_off), .line_valid(line_valid),
    .fill_valid(fill_valid), .host_wr(host_wr), .host_off(host_off),
    .fetch_ready(fetch_ready), .fetch_miss(fetch_miss),
    .fill_req(fill_req), .fill_line(fill_line), .fill_idx(fill_idx),
    .fill_we(fill_we), .fill_set(fill_set),
    .port_re(port_re), .port_addr(port_addr)
  );

  // R1
  outside_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (host_re && !in_win) |=> host_rdata == 8'h00);
endmodule

// File: tb/seg_icache_test.sv
module seg_icache_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_we = 1'b0, host_re = 1'b0;
  logic [9:0]  host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  host_rdata;
  logic        base_load = 1'b0;
  logic [15:0] base_val = '0;
  logic [15:0] cbase;
  logic        fetch_req = 1'b0;
  logic [8:0]  fetch_off = '0;
  logic        fetch_ready, fetch_miss;
  logic [7:0]  fetch_data;
  logic        fill_req;
  logic [15:0] fill_addr;
  logic        fill_valid = 1'b0;
  logic [7:0]  fill_data = '0;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_icache uut (
    .clk(clk), .rst(rst),
    .host_we(host_we), .host_re(host_re), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .base_load(base_load), .base_val(base_val), .cbase(cbase),
    .fetch_req(fetch_req), .fetch_off(fetch_off), .fetch_ready(fetch_ready),
    .fetch_miss(fetch_miss), .fetch_data(fetch_data),
    .fill_req(fill_req), .fill_addr(fill_addr),
    .fill_valid(fill_valid), .fill_data(fill_data)
  );

  function automatic logic [7:0] ext_byte(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic host_write(input logic [9:0] a, input logic [7:0] d);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic host_read(input logic [9:0] a, output logic [7:0] d);
    host_re = 1'b1; host_addr = a;
    @(negedge clk);
    d = host_rdata;
    host_re = 1'b0;
  endtask

  task automatic set_base(input logic [15:0] v);
    base_load = 1'b1; base_val = v;
    @(negedge clk);
    base_load = 1'b0;
  endtask

  task automatic fetch(input logic [8:0] off, output logic rdy, output logic ms, output logic [7:0] d);
    fetch_req = 1'b1; fetch_off = off;
    @(negedge clk);
    rdy = fetch_ready; ms = fetch_miss; d = fetch_data;
    fetch_req = 1'b0;
  endtask

  // serves one line; poke issues a stray fetch mid-fill (R7)
  task automatic serve_fill(input logic [15:0] line_base, input logic [7:0] exp_byte, input bit poke);
    for (int i = 0; i < 16; i++) begin
      check(fill_req == 1'b1, "R5 fill_req held", 32'(fill_req), 32'd1);
      check(fill_addr == line_base + 16'(i), "R5 ascending fill address", 32'(fill_addr), 32'(line_base + 16'(i)));
      if (poke && i == 5) begin fetch_req = 1'b1; fetch_off = 9'h000; end
      else fetch_req = 1'b0;
      fill_valid = 1'b1; fill_data = ext_byte(fill_addr);
      @(negedge clk);
      fill_valid = 1'b0; fetch_req = 1'b0;
      if (poke && i == 5)
        check(!fetch_miss && !fetch_ready, "R7 stray fetch ignored", 32'({fetch_miss, fetch_ready}), 32'd0);
    end
    check(fill_req == 1'b0, "R6 fill_req drops after last byte", 32'(fill_req), 32'd0);
    @(negedge clk);
    check(fetch_ready == 1'b1, "R6 ready after fill", 32'(fetch_ready), 32'd1);
    check(fetch_data == exp_byte, "R6 missed byte delivered", 32'(fetch_data), 32'(exp_byte));
  endtask

  task automatic test_reset();
    check(!fetch_ready && !fetch_miss, "R2 reset fetch outputs idle", 32'({fetch_ready, fetch_miss}), 32'd0);
    check(fill_req == 1'b0, "R5 reset no fill", 32'(fill_req), 32'd0);
    check(cbase == 16'h0000, "R4 reset base", 32'(cbase), 32'd0);
  endtask

  task automatic test_window();
    logic [7:0] d;
    host_write(10'h100, 8'h11);
    host_write(10'h2FF, 8'h22);
    host_write(10'h0FF, 8'h99);
    host_write(10'h300, 8'h77);
    host_read(10'h100, d); check(d == 8'h11, "R1 first window byte", 32'(d), 32'h11);
    host_read(10'h2FF, d); check(d == 8'h22, "R1 last window byte", 32'(d), 32'h22);
    host_read(10'h0FF, d); check(d == 8'h00, "R1 below window reads zero", 32'(d), 32'h00);
    host_read(10'h300, d); check(d == 8'h00, "R1 above window reads zero", 32'(d), 32'h00);
  endtask

  task automatic test_partial_line();
    logic r, m; logic [7:0] d;
    set_base(16'h1235);
    check(cbase == 16'h1230, "R4 base aligned", 32'(cbase), 32'h1230);
    for (int i = 0; i < 15; i++) host_write(10'h120 + 10'(i), 8'h80 + 8'(i));
    fetch(9'h024, r, m, d);
    check(m == 1'b1 && r == 1'b0, "R3 partial line misses", 32'({r, m}), 32'b01);
    check(fill_req == 1'b1, "R2 fill starts on miss", 32'(fill_req), 32'd1);
    serve_fill(16'h1250, ext_byte(16'h1254), 1'b1);
    fetch(9'h024, r, m, d);
    check(r == 1'b1 && d == ext_byte(16'h1254), "R6 line valid after fill", 32'({r, d}), 32'({1'b1, ext_byte(16'h1254)}));
  endtask

  task automatic test_complete_line();
    logic r, m; logic [7:0] d;
    for (int i = 0; i < 16; i++) host_write(10'h130 + 10'(i), 8'h40 + 8'(i));
    fetch(9'h037, r, m, d);
    check(r == 1'b1 && m == 1'b0 && d == 8'h47, "R3 full host line hits", 32'({r, m, d}), 32'({2'b10, 8'h47}));
    host_write(10'h140, 8'hC0);
    host_write(10'h14F, 8'hCF);
    fetch(9'h040, r, m, d);
    check(r == 1'b1 && d == 8'hC0, "R3 short program runs", 32'({r, d}), 32'({1'b1, 8'hC0}));
  endtask

  task automatic test_flush();
    logic r, m; logic [7:0] d;
    set_base(16'h2008);
    check(cbase == 16'h2000, "R4 new base aligned", 32'(cbase), 32'h2000);
    fetch(9'h037, r, m, d);
    check(m == 1'b1 && r == 1'b0, "R4 flush invalidates line", 32'({r, m}), 32'b01);
    serve_fill(16'h2030, ext_byte(16'h2037), 1'b0);
  endtask

  task automatic test_host_wins();
    logic r, m; logic [7:0] d;
    set_base(16'h4000);
    fetch(9'h05A, r, m, d);
    check(m == 1'b1, "R2 miss on fresh line", 32'(m), 32'd1);
    for (int i = 0; i < 16; i++) begin
      check(fill_addr == 16'h4050 + 16'(i), "R5 fill address", 32'(fill_addr), 32'(16'h4050 + 16'(i)));
      host_we = 1'b0;
      if (i == 0)  begin host_we = 1'b1; host_addr = 10'h153; host_wdata = 8'hA3; end
      if (i == 10) begin host_we = 1'b1; host_addr = 10'h15A; host_wdata = 8'hEE; end
      fill_valid = 1'b1; fill_data = ext_byte(fill_addr);
      @(negedge clk);
      fill_valid = 1'b0; host_we = 1'b0;
    end
    @(negedge clk);
    check(fetch_ready && fetch_data == 8'hEE, "R8 same-cycle host write wins", 32'({fetch_ready, fetch_data}), 32'({1'b1, 8'hEE}));
    host_read(10'h153, d); check(d == 8'hA3, "R8 earlier host write wins", 32'(d), 32'hA3);
    host_read(10'h154, d); check(d == ext_byte(16'h4054), "R8 other bytes from fill", 32'(d), 32'(ext_byte(16'h4054)));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    test_window();
    test_partial_line();
    test_complete_line();
    test_flush();
    test_host_wins();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule